// File: doc/BRIEF.md
# Per-Source Configurable Interrupt Controller

This block collects six condition inputs into one 8-bit status register and drives a single interrupt line. Each source has an enable bit and a 2-bit trigger code. The trigger code selects whether the source fires when its condition appears, when it goes away, or for as long as it lasts. The two bits of each code sit in two separate mode registers, each aligned bit for bit with the status register. The enable bit controls both whether the status bit can be set and whether it can reach the interrupt line.

Software reaches the block through a small register port with four word addresses. Reading status through the port clears the bits latched by edge events. A separate 2-bit input selects the electrical behaviour of the interrupt line: active-high, active-low, or an open-drain style active-low line carried as an output enable.

Top module: `irq_hub`

## Requirements
- R1: After reset the status, enable, mode-high and mode-low registers all read 0x00, `irq_o` is 0 and `irq_oe_o` is 1, with `pol_cfg_i` = 00.
- R2: The port addresses are: 0 = status (read-only), 1 = enable, 2 = mode-high, 3 = mode-low. `rdata_o` always shows the register selected by `addr_i`. Bits 6 and 2 read 0 in every register, whatever was written. A write to address 0 has no effect.
- R3: A source whose enable bit (bit i of address 1) is 0 never sets its status bit, and does not drive the interrupt line.
- R4: Trigger code {mode-high[i], mode-low[i]} = 00 (rising): when `cond_i[i]` goes from 0 to 1, status bit i is 1 after the next clock edge and stays set once the condition is removed.
- R5: Code 01 (falling): when `cond_i[i]` goes from 1 to 0, status bit i is 1 after the next clock edge, and it is sticky.
- R6: Codes 10 and 11 (level): status bit i equals enable[i] AND `cond_i[i]` as sampled at the previous clock edge, and a status read does not clear it.
- R7: A cycle with `rd_i`=1 and `addr_i`=0 returns the current status on `rdata_o` and clears the edge-mode status bits at that clock edge.
- R8: An edge event in the same cycle as a status read leaves its status bit set after the read.
- R9: The interrupt is pending exactly when some status bit i is 1 while enable[i] is 1.
- R10: With `pol_cfg_i`=00, `irq_o` equals pending and `irq_oe_o`=1. With 01, `irq_o` = NOT pending and `irq_oe_o`=1. With 1x, `irq_o`=0 and `irq_oe_o` equals pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | 8 | Condition inputs; bits 6 and 2 are unused |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (clears status when addr is 0) |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| pol_cfg_i | input | 2 | Interrupt line polarity and drive style |
| irq_o | output | 1 | Interrupt line level |
| irq_oe_o | output | 1 | Interrupt line output enable |

## Verification
A wrong edge-detect history or a wrong trigger decode shows up at the ports one clock after the stimulating edge, as a wrong status value and a wrong level on the interrupt line. A clear that is lost or misapplied shows up on the first status read after the read strobe. An enable that leaks through shows up as an interrupt raised by a blocked source. The stimulus therefore pairs each condition pattern with a status read in the very next cycle. It also crosses every trigger code with enabled and blocked sources, and it checks the read-coincident event and each polarity setting directly.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int          REG_W       = 8;
    localparam int          ADDR_W      = 2;
    localparam logic [7:0]  SRC_PRESENT = 8'hBB;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'b00,
        TRIG_FALL  = 2'b01,
        TRIG_LEVEL = 2'b10,
        TRIG_HOLD  = 2'b11
    } trig_e;

    typedef enum logic [1:0] {
        ADR_STATUS = 2'd0,
        ADR_ENABLE = 2'd1,
        ADR_MODE_H = 2'd2,
        ADR_MODE_L = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cond_i,
    input  logic       en_i,
    input  logic [1:0] trig_i,
    input  logic       clr_i,
    output logic       stat_o
);
    import irq_pkg::*;

    typedef struct packed {
        logic cond;
        logic stat;
    } cell_st_t;

    cell_st_t cell_d, cell_q;
    logic     rise_w, fall_w, level_w, event_w;

    always_comb begin
        cell_d      = cell_q;
        cell_d.cond = cond_i;
        rise_w      = cond_i & ~cell_q.cond;
        fall_w      = ~cond_i & cell_q.cond;
        level_w     = trig_i[1];
        event_w     = 1'b0;
        if (level_w) begin
            cell_d.stat = en_i & cond_i;
        end else begin
            event_w     = en_i & ((trig_i == TRIG_FALL) ? fall_w : rise_w);
            cell_d.stat = event_w | (cell_q.stat & ~clr_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end

    assign stat_o = cell_q.stat;

    assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !stat_o) |=> !stat_o);
    assert_rise_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && trig_i == TRIG_RISE && $rose(cond_i)) |=> stat_o);
    assert_fall_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && trig_i == TRIG_FALL && $fell(cond_i)) |=> stat_o);
    assert_level_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i[1] |=> (stat_o == $past(en_i && cond_i)));
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !trig_i[1] && $stable(cond_i)) |=> !stat_o);
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int               W       = irq_pkg::REG_W,
    parameter int               AW      = irq_pkg::ADDR_W,
    parameter logic [W-1:0]     PRESENT = irq_pkg::SRC_PRESENT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [W-1:0]  status_i,
    output logic [W-1:0]  en_o,
    output logic [W-1:0]  mode_h_o,
    output logic [W-1:0]  mode_l_o,
    output logic [W-1:0]  rdata_o,
    output logic          clr_o
);
    import irq_pkg::*;

    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] mh;
        logic [W-1:0] ml;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            unique case (addr_i)
                ADR_ENABLE: cfg_d.en = wdata_i & PRESENT;
                ADR_MODE_H: cfg_d.mh = wdata_i & PRESENT;
                ADR_MODE_L: cfg_d.ml = wdata_i & PRESENT;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        unique case (addr_i)
            ADR_STATUS: rdata_o = status_i & PRESENT;
            ADR_ENABLE: rdata_o = cfg_q.en;
            ADR_MODE_H: rdata_o = cfg_q.mh;
            default:    rdata_o = cfg_q.ml;
        endcase
    end

    assign clr_o    = rd_i && (addr_i == ADR_STATUS);
    assign en_o     = cfg_q.en;
    assign mode_h_o = cfg_q.mh;
    assign mode_l_o = cfg_q.ml;

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o & ~PRESENT) == '0);
    assert_status_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADR_STATUS) |=> $stable(cfg_q));
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv (
    input  logic       pend_i,
    input  logic [1:0] pol_i,
    output logic       irq_o,
    output logic       oe_o
);
    always_comb begin
        if (pol_i[1]) begin
            irq_o = 1'b0;
            oe_o  = pend_i;
        end else begin
            irq_o = pol_i[0] ? ~pend_i : pend_i;
            oe_o  = 1'b1;
        end
    end

    always_comb begin
        assert_line_drive_R10: assert (pol_i[1] ? (irq_o == 1'b0) : (oe_o == 1'b1));
    end
endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
    parameter int                   W       = irq_pkg::REG_W,
    parameter int                   AW      = irq_pkg::ADDR_W,
    parameter logic [W-1:0]         PRESENT = irq_pkg::SRC_PRESENT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  cond_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  rdata_o,
    input  logic [1:0]    pol_cfg_i,
    output logic          irq_o,
    output logic          irq_oe_o
);
    logic [W-1:0] status_w, en_w, mh_w, ml_w;
    logic         clr_w, pend_w;

    irq_cfg_regs #(.W(W), .AW(AW), .PRESENT(PRESENT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_i),
        .rd_i     (rd_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .status_i (status_w),
        .en_o     (en_w),
        .mode_h_o (mh_w),
        .mode_l_o (ml_w),
        .rdata_o  (rdata_o),
        .clr_o    (clr_w)
    );

    for (genvar i = 0; i < W; i++) begin : g_src
        if (PRESENT[i]) begin : g_live
            irq_src_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .cond_i (cond_i[i]),
                .en_i   (en_w[i]),
                .trig_i ({mh_w[i], ml_w[i]}),
                .clr_i  (clr_w),
                .stat_o (status_w[i])
            );
        end else begin : g_hole
            assign status_w[i] = 1'b0;
        end
    end

    assign pend_w = |(status_w & en_w);

    irq_pin_drv u_drv (
        .pend_i (pend_w),
        .pol_i  (pol_cfg_i),
        .irq_o  (irq_o),
        .oe_o   (irq_oe_o)
    );

    assert_pending_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_cfg_i == 2'b00 && $past(en_w) == en_w) |-> (irq_o == |(status_w & en_w)));
    assert_coincident_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w && en_w[0] && !mh_w[0] && !ml_w[0] && $rose(cond_i[0])) |=> status_w[0]);
endmodule

// File: tb/irq_hub_test.sv
module irq_hub_test;
    localparam logic [7:0] PRES = 8'hBB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cond = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] pol = 2'b00;
    logic       irq, irq_oe;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_hub uut (
        .clk(clk), .rst_n(rst_n), .cond_i(cond), .wr_i(wr), .rd_i(rd),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pol_cfg_i(pol),
        .irq_o(irq), .irq_oe_o(irq_oe)
    );

    // fields: enable, mode-high, mode-low, cond before, cond after
    localparam logic [39:0] VEC [8] = '{
        {8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF},
        {8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00},
        {8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00},
        {8'hFF, 8'hFF, 8'h00, 8'h00, 8'hA5},
        {8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h3C},
        {8'h0F, 8'h00, 8'h00, 8'h00, 8'hFF},
        {8'hFF, 8'hF0, 8'h0F, 8'h5A, 8'hA5},
        {8'h00, 8'hFF, 8'h00, 8'hFF, 8'hFF}
    };

    function automatic logic [7:0] model(input logic [7:0] en, mh, ml, pre, post);
        logic [7:0] r = '0;
        for (int i = 0; i < 8; i++) begin
            if (PRES[i] && en[i]) begin
                case ({mh[i], ml[i]})
                    2'b00:   r[i] = ~pre[i] & post[i];
                    2'b01:   r[i] = pre[i] & ~post[i];
                    default: r[i] = post[i];
                endcase
            end
        end
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick();
        wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd = 1'b0;
        #1 d = rdata;
    endtask

    task automatic read_clear();
        addr = 2'd0; rd = 1'b1;
        tick();
        rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1: reset values
        for (int a = 0; a < 4; a++) begin
            peek(a[1:0], v);
            check("R1 register reset", v, 8'h00);
        end
        check("R1 irq line idle", {6'd0, irq, irq_oe}, 8'h01);

        // R2: reserved bits and read-only status
        wreg(2'd1, 8'hFF); peek(2'd1, v); check("R2 enable reserved bits", v, 8'hBB);
        wreg(2'd2, 8'hFF); peek(2'd2, v); check("R2 mode-high reserved bits", v, 8'hBB);
        wreg(2'd3, 8'hFF); peek(2'd3, v); check("R2 mode-low reserved bits", v, 8'hBB);
        wreg(2'd0, 8'hFF); peek(2'd0, v); check("R2 status write ignored", v, 8'h00);

        // Table: R3 R4 R5 R6 R7 R9
        for (int k = 0; k < 8; k++) begin
            logic [7:0] en, mh, ml, pre, post, exp;
            {en, mh, ml, pre, post} = VEC[k];
            wreg(2'd1, en); wreg(2'd2, mh); wreg(2'd3, ml);
            cond = pre;
            tick(); tick();
            read_clear();
            cond = post;
            tick();
            exp = model(en, mh, ml, pre, post);
            peek(2'd0, v);
            check($sformatf("R3/R4/R5/R6 vector %0d status", k), v, exp);
            check($sformatf("R9 vector %0d irq", k), {7'd0, irq}, {7'd0, |(exp & en & PRES)});
        end

        // R4: rising edge sticky after condition removed
        cond = 8'h00; wreg(2'd1, 8'h01); wreg(2'd2, 8'h00); wreg(2'd3, 8'h00);
        read_clear();
        cond = 8'h01; tick(); cond = 8'h00; tick(); tick();
        peek(2'd0, v); check("R4 rising bit sticky", v, 8'h01);

        // R7: read returns value, then clears
        addr = 2'd0; rd = 1'b1; #1 v = rdata;
        check("R7 read returns status", v, 8'h01);
        tick(); rd = 1'b0;
        peek(2'd0, v); check("R7 status cleared by read", v, 8'h00);

        // R6: level bit survives a read
        wreg(2'd2, 8'h01); cond = 8'h01; tick();
        read_clear();
        peek(2'd0, v); check("R6 level not cleared by read", v, 8'h01);
        cond = 8'h00; tick();
        peek(2'd0, v); check("R6 level follows condition", v, 8'h00);

        // R8: event in read cycle survives
        wreg(2'd2, 8'h00); tick();
        addr = 2'd0; rd = 1'b1; cond = 8'h01;
        tick(); rd = 1'b0;
        peek(2'd0, v); check("R8 coincident event kept", v, 8'h01);

        // R10: polarity variants with pending set
        pol = 2'b00; #1 check("R10 active-high pending", {6'd0, irq, irq_oe}, 8'h03);
        pol = 2'b01; #1 check("R10 active-low pending", {6'd0, irq, irq_oe}, 8'h01);
        pol = 2'b10; #1 check("R10 open-drain pending", {6'd0, irq, irq_oe}, 8'h01);
        read_clear();
        #1 check("R10 open-drain idle", {6'd0, irq, irq_oe}, 8'h00);
        pol = 2'b01; #1 check("R10 active-low idle", {6'd0, irq, irq_oe}, 8'h03);
        pol = 2'b00;

        // R3/R9: disabling a set source drops the line but keeps status
        cond = 8'h00; tick(); cond = 8'h01; tick();
        wreg(2'd1, 8'h00);
        peek(2'd0, v); check("R3 status kept after disable", v, 8'h01);
        check("R9 disabled source no irq", {7'd0, irq}, 8'h00);
        cond = 8'h00; tick(); cond = 8'h01; read_clear(); tick();
        peek(2'd0, v); check("R3 disabled source cannot set", v, 8'h00);

        finish_run();
    end
endmodule